// File: doc/BRIEF.md
# Pipelined Processor Bus Cycle Controller

This block sequences the local-bus cycles of a 32-bit processor. A requester offers one transfer at a time: a byte address, byte enables, a direction and a memory-or-I/O select. The controller places that transfer on the external bus, together with a one-clock address-status strobe. It then holds the bus until the ready input is sampled active. The only clock input is a double-rate clock. The controller divides it by two to form the processor clock and marks the two halves of each processor clock as phase 1 and phase 2. All bus decisions are taken at the edge that ends phase 2.

A plain cycle has a first state, which carries the strobe, and one or more second states. Each extra second state is a wait state. When pipelining is enabled and the next-address input is seen during a second state that has not yet ended, the controller accepts the following request early. It then drives that request's address and status during the remaining second states of the current cycle, so the overlapped cycle starts directly in its second state. A cycle that begins from the idle state always goes through a first state. Pipelined transfers therefore reach one transfer every two processor clocks, and each one gets three clocks between its address and its data.

Top module: `bus_cycle_ctl`

## Requirements
- R1: `phase2` toggles on every `clk2` rising edge and `phase1` is its complement. `proc_clk` equals `phase1`, so the processor clock runs at half the rate of `clk2`. The first `clk2` period after reset is phase 1.
- R2: While `rst_n` is low, the following outputs are low: `bus_state`, `ads`, `pipelined` and `req_take`. `phase1` is high.
- R3: With `req_valid` low, the controller stays idle (`bus_state` = 0) and keeps `ads` and `req_take` low.
- R4: The `bus_state` encoding is 0 idle, 1 first state, 2 second state, 3 second state with the next cycle's address already driven. A first state is always followed by a second state. `ready` is sampled only at the end of a processor clock in state 2 or 3: low repeats that state as a wait state, and high ends the cycle. A non-pipelined transfer with w wait states therefore lasts 2+w processor clocks.
- R5: A request is accepted early if all of these hold at the end of a state-2 clock: `pipe_en` is high, `next_req` is high, `req_valid` is high and `ready` is low. The following clock is then state 3, and the bus shows the new request's address and status. When `ready` is later sampled high in state 3, the new cycle continues directly in state 2 with `pipelined` high. `pipelined` returns low in state 1 and in idle.
- R6: A request accepted from idle always starts with state 1 and `pipelined` low, whatever the values of `pipe_en` and `next_req`.
- R7: If `pipe_en` or `next_req` is low, state 3 never occurs.
- R8: `ads` is high for exactly one processor clock per cycle: the state-1 clock, or the first state-3 clock.
- R9: For a memory transfer, `bus_mio` = 1 and `bus_addr` carries all 32 bits. For an I/O transfer, `bus_mio` = 0, only address bits 15:0 are driven and bits 31:16 are zero. `bus_be` and `bus_wr` follow the accepted request.
- R10: `req_take` is high only during phase 2 of the processor clock in which a request is accepted, once per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2 | input | 1 | Double-rate input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A transfer request is pending |
| req_addr | input | 32 | Byte address of the pending request |
| req_be | input | 4 | Byte enables of the pending request |
| req_write | input | 1 | Pending request is a write |
| req_io | input | 1 | Pending request targets I/O space |
| pipe_en | input | 1 | Allows address pipelining |
| next_req | input | 1 | Next-address request from the bus target |
| ready | input | 1 | Active-high cycle-end input from the bus target |
| req_take | output | 1 | Pending request accepted this processor clock |
| proc_clk | output | 1 | Processor clock, high during phase 1 |
| phase1 | output | 1 | First half of the processor clock |
| phase2 | output | 1 | Second half of the processor clock |
| bus_state | output | 2 | Current bus state code |
| bus_addr | output | 32 | Bus address |
| bus_be | output | 4 | Bus byte enables |
| bus_mio | output | 1 | 1 for memory, 0 for I/O |
| bus_wr | output | 1 | 1 for write, 0 for read |
| ads | output | 1 | Address-status strobe |
| pipelined | output | 1 | Current cycle was started by pipelining |

## Verification
The bench builds the block with its default 32-bit address, 16-bit I/O address and 4 byte enables. It sweeps every combination of pipelining enable, next-address request, zero to three wait states and memory-only or mixed I/O traffic, with five queued transfers each. For each case it checks the closed-form processor-clock count (2+w per transfer, or one first state plus w+1 clocks per transfer when overlapping). It also checks the number of overlapped cycles, the address, status and byte enables at every strobe, and I/O address masking. Small wait counts are enough to reach the cases that matter: zero waits, where overlap cannot happen, and one wait, the fastest pipelined rate.

// File: rtl/bus_cycle_ctl.sv
`timescale 1ns/1ps
module bus_cycle_ctl #(
  parameter int AW    = 32,
  parameter int IO_AW = 16,
  parameter int BEW   = 4
) (
  input  logic           clk2,
  input  logic           rst_n,
  input  logic           req_valid,
  input  logic [AW-1:0]  req_addr,
  input  logic [BEW-1:0] req_be,
  input  logic           req_write,
  input  logic           req_io,
  input  logic           pipe_en,
  input  logic           next_req,
  input  logic           ready,
  output logic           req_take,
  output logic           proc_clk,
  output logic           phase1,
  output logic           phase2,
  output logic [1:0]     bus_state,
  output logic [AW-1:0]  bus_addr,
  output logic [BEW-1:0] bus_be,
  output logic           bus_mio,
  output logic           bus_wr,
  output logic           ads,
  output logic           pipelined
);
  localparam int HIW = AW - IO_AW;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_T1   = 2'd1,
    S_T2   = 2'd2,
    S_T2N  = 2'd3
  } st_t;

  logic           ph2_q;
  st_t            st_q, st_n;
  logic           ads_q, pipe_q, pipe_n;
  logic [AW-1:0]  addr_q;
  logic [BEW-1:0] be_q;
  logic           mio_q, wr_q;
  logic           issue, fresh, accept;
  logic [AW-1:0]  addr_map;

  assign issue  = (st_q == S_T2) && !ready && pipe_en && next_req && req_valid;
  assign fresh  = req_valid && ((st_q == S_IDLE) || ((st_q == S_T2) && ready));
  assign accept = issue || fresh;

  assign addr_map = req_io ? {{HIW{1'b0}}, req_addr[IO_AW-1:0]} : req_addr;

  always_comb begin
    st_n = st_q;
    unique case (st_q)
      S_IDLE: if (req_valid) st_n = S_T1;
      S_T1:   st_n = S_T2;
      S_T2: begin
        if (ready)      st_n = req_valid ? S_T1 : S_IDLE;
        else if (issue) st_n = S_T2N;
      end
      S_T2N: if (ready) st_n = S_T2;
      default: st_n = S_IDLE;
    endcase
  end

  always_comb begin
    pipe_n = pipe_q;
    if (st_n == S_T1 || st_n == S_IDLE) pipe_n = 1'b0;
    else if (st_q == S_T2N && ready)    pipe_n = 1'b1;
  end

  always_ff @(posedge clk2 or negedge rst_n) begin
    if (!rst_n) begin
      ph2_q  <= 1'b0;
      st_q   <= S_IDLE;
      ads_q  <= 1'b0;
      pipe_q <= 1'b0;
      addr_q <= '0;
      be_q   <= '0;
      mio_q  <= 1'b0;
      wr_q   <= 1'b0;
    end else begin
      ph2_q <= !ph2_q;
      if (ph2_q) begin
        st_q   <= st_n;
        ads_q  <= (st_n == S_T1) || issue;
        pipe_q <= pipe_n;
        if (accept) begin
          addr_q <= addr_map;
          be_q   <= req_be;
          mio_q  <= !req_io;
          wr_q   <= req_write;
        end
      end
    end
  end

  assign phase2    = ph2_q;
  assign phase1    = !ph2_q;
  assign proc_clk  = !ph2_q;
  assign req_take  = accept && ph2_q;
  assign bus_state = st_q;
  assign bus_addr  = addr_q;
  assign bus_be    = be_q;
  assign bus_mio   = mio_q;
  assign bus_wr    = wr_q;
  assign ads       = ads_q;
  assign pipelined = pipe_q;
endmodule

// File: rtl/bus_cycle_ctl_chk.sv
`timescale 1ns/1ps
module bus_cycle_ctl_chk #(
  parameter int AW    = 32,
  parameter int IO_AW = 16
) (
  input logic          clk2,
  input logic          rst_n,
  input logic          phase1,
  input logic          phase2,
  input logic [1:0]    bus_state,
  input logic          ads,
  input logic          pipelined,
  input logic          pipe_en,
  input logic          bus_mio,
  input logic [AW-1:0] bus_addr
);
  // R1
  phase_hi_lo_chk: assert property (@(posedge clk2) disable iff (!rst_n)
    phase2 |=> !phase2);
  // R1
  phase_lo_hi_chk: assert property (@(posedge clk2) disable iff (!rst_n)
    !phase2 |=> phase2);
  // R4
  state_hold_chk: assert property (@(posedge clk2) disable iff (!rst_n)
    phase1 |=> $stable(bus_state));
  // R4
  first_then_second_chk: assert property (@(posedge clk2) disable iff (!rst_n)
    (bus_state == 2'd1 && phase2) |=> bus_state == 2'd2);
  // R6
  idle_exit_chk: assert property (@(posedge clk2) disable iff (!rst_n)
    (bus_state == 2'd0 && phase2) |=> (bus_state == 2'd0 || (bus_state == 2'd1 && !pipelined)));
  // R7
  no_overlap_chk: assert property (@(posedge clk2) disable iff (!rst_n)
    (bus_state == 2'd2 && phase2 && !pipe_en) |=> bus_state != 2'd3);
  // R8
  strobe_once_chk: assert property (@(posedge clk2) disable iff (!rst_n)
    (ads && phase2) |=> !ads);
  // R5
  pipe_entry_chk: assert property (@(posedge clk2) disable iff (!rst_n)
    $rose(pipelined) |-> (bus_state == 2'd2 && $past(bus_state) == 2'd3));
  // R9
  io_upper_zero_chk: assert property (@(posedge clk2) disable iff (!rst_n)
    !bus_mio |-> bus_addr[AW-1:IO_AW] == '0);
endmodule

bind bus_cycle_ctl bus_cycle_ctl_chk #(.AW(AW), .IO_AW(IO_AW)) u_chk (
  .clk2(clk2), .rst_n(rst_n), .phase1(phase1), .phase2(phase2),
  .bus_state(bus_state), .ads(ads), .pipelined(pipelined), .pipe_en(pipe_en),
  .bus_mio(bus_mio), .bus_addr(bus_addr)
);

// File: tb/bus_cycle_ctl_test.sv
`timescale 1ns/1ps
module bus_cycle_ctl_test;
  localparam int N = 5;

  logic        clk2 = 1'b0, rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_io = 1'b0;
  logic [31:0] req_addr = '0;
  logic [3:0]  req_be = '0;
  logic        pipe_en = 1'b0, next_req = 1'b0, ready = 1'b0;
  logic        req_take, proc_clk, phase1, phase2, bus_mio, bus_wr, ads, pipelined;
  logic [1:0]  bus_state;
  logic [31:0] bus_addr;
  logic [3:0]  bus_be;

  int checks = 0, errors = 0, cyc = 0;

  bus_cycle_ctl uut (
    .clk2(clk2), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_be(req_be), .req_write(req_write), .req_io(req_io), .pipe_en(pipe_en),
    .next_req(next_req), .ready(ready), .req_take(req_take), .proc_clk(proc_clk),
    .phase1(phase1), .phase2(phase2), .bus_state(bus_state), .bus_addr(bus_addr),
    .bus_be(bus_be), .bus_mio(bus_mio), .bus_wr(bus_wr), .ads(ads), .pipelined(pipelined)
  );

  always #2.5 clk2 = ~clk2;

  always @(posedge clk2) begin
    cyc++;
    if (cyc > 100000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d clk2 cycles expected fewer", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] raw_addr(input int k, input int w, input bit pe);
    return 32'hC3A5_0000 ^ (k * 32'h0011_0313) ^ (w << 28) ^ (32'(pe) << 20);
  endfunction

  function automatic bit is_io(input int k, input bit iom);
    return iom && k[0];
  endfunction

  function automatic logic [3:0] be_of(input int k);
    return 4'hF >> (k % 4);
  endfunction

  task automatic drive(input int k, input int w, input bit pe, input bit iom);
    req_valid = 1'b1;
    req_addr  = raw_addr(k, w, pe);
    req_be    = be_of(k);
    req_write = k[0] ^ w[0];
    req_io    = is_io(k, iom);
  endtask

  task automatic sync_edge();
    do @(negedge clk2); while (!phase2);
    @(posedge clk2);
  endtask

  task automatic run_seq(input bit pe, input bit nr, input int w, input bit iom);
    int idx = 0, nclk = 0, nads = 0, npipe = 0, ntake = 0, wcnt = 0;
    bit seen3 = 0, took;
    logic [31:0] ea;
    int exp_clk;
    pipe_en = pe; next_req = nr;
    for (int g = 0; g < 400; g++) begin
      #1;
      if (idx == N && bus_state == 2'd0 && nads > 0) break;
      if (idx < N) drive(idx, w, pe, iom); else req_valid = 1'b0;
      ready = (bus_state >= 2'd2) ? (wcnt == w) : (w == 0);
      @(negedge clk2);
      if (req_take) check(1'b0, "R10 take in phase1", 32'(req_take), 0);
      @(negedge clk2);
      if (bus_state != 2'd0) nclk++;
      if (bus_state == 2'd3) seen3 = 1;
      if (ads) begin
        ea = raw_addr(nads, w, pe);
        if (is_io(nads, iom)) ea = {16'h0, ea[15:0]};
        check(bus_addr == ea, "R9 address", bus_addr, ea);
        check(bus_mio == !is_io(nads, iom), "R9 mio", 32'(bus_mio), 32'(!is_io(nads, iom)));
        check(bus_wr == (nads[0] ^ w[0]) && bus_be == be_of(nads), "R9 wr/be",
              {27'h0, bus_wr, bus_be}, {27'h0, 1'(nads[0] ^ w[0]), be_of(nads)});
        if (nads == 0)
          check(bus_state == 2'd1 && !pipelined, "R6 first from idle", 32'(bus_state), 1);
        if (bus_state == 2'd3) npipe++;
        nads++;
      end
      took = req_take;
      if (took) ntake++;
      if (bus_state >= 2'd2) wcnt = ready ? 0 : wcnt + 1;
      @(posedge clk2);
      if (took) idx++;
    end
    exp_clk = (pe && nr && w >= 1) ? 1 + N * (w + 1) : N * (2 + w);
    check(nclk == exp_clk, (pe && nr) ? "R5 pipelined clock count" : "R4 cycle clock count", nclk, exp_clk);
    check(nads == N, "R8 strobe count", nads, N);
    check(npipe == ((pe && nr && w >= 1) ? N - 1 : 0), "R5 overlapped cycles", npipe,
          (pe && nr && w >= 1) ? N - 1 : 0);
    check(ntake == N, "R10 take count", ntake, N);
    if (!(pe && nr)) check(!seen3, "R7 no state 3", 32'(seen3), 0);
    check(bus_state == 2'd0 && !pipelined, "R5 idle clears pipelined", {30'h0, bus_state} | 32'(pipelined) << 4, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk2);
    #1;
    check(bus_state == 2'd0 && !ads && !pipelined && !req_take && phase1, "R2 reset state",
          {26'h0, bus_state, ads, pipelined, req_take, phase1}, 32'h1);
    @(negedge clk2);
    rst_n = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk2);
      check(phase2 == (i % 2 == 0) && phase1 == !phase2 && proc_clk == phase1, "R1 phase divider",
            {29'h0, phase2, phase1, proc_clk}, {29'h0, 1'(i % 2 == 0), 1'(i % 2 != 0), 1'(i % 2 != 0)});
    end
    sync_edge();
    pipe_en = 1'b1; next_req = 1'b1;
    for (int i = 0; i < 6; i++) begin
      #1;
      @(negedge clk2); @(negedge clk2);
      check(bus_state == 2'd0 && !ads && !req_take, "R3 idle without request",
            {29'h0, bus_state, ads}, 0);
      @(posedge clk2);
    end
    for (int pe = 0; pe < 2; pe++)
      for (int nr = 0; nr < 2; nr++)
        for (int w = 0; w < 4; w++)
          for (int iom = 0; iom < 2; iom++)
            run_seq(1'(pe), 1'(nr), w, 1'(iom));
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule